// File: doc/BRIEF.md
# Clock Throttling Speedup Controller

This block throttles a processor clock by running a simple duty-cycle pattern on a suspend request line. It lowers the request for a programmed number of run cycles and raises it for a programmed number of acknowledged suspend cycles. A request/acknowledge handshake governs the pattern: once the request drops, the next run phase does not begin until the acknowledge has been released.

Two sources of system activity can lift the throttling for a while. The first is any unmasked interrupt line or an SMI indication. The second is video activity, which is either an explicit pulse or a bus access that the block decodes as a legacy display access: I/O ports 3B0h–3DFh, or memory A0000h–B7FFFh. Each source loads its own 8-bit window counter with its own programmed duration. The counters count down on an external timebase tick. While either counter is nonzero, the suspend request is held low. All of this happens only when the global power-management enable and the modulation mode are both set.

Top module: `throttle_speedup_ctrl`

## Requirements
- R1: After a synchronous reset, `susp_req` and `speedup_active` are 0.
- R2: While `pm_enable` is 0, no speedup window starts, `speedup_active` is 0 from the next cycle on, and `susp_req` stays 0.
- R3: With `pm_enable` and `mod_enable` set and no window running, `susp_req` repeats a pattern. It is low for `run_len` cycles (at least 1) and then high until `susp_len` cycles (at least 1) have passed with `susp_ack` high. After it drops, a new run phase starts only in the cycle after `susp_ack` is seen low. With an acknowledge that follows the request one cycle late, the request is high for `susp_len`+1 cycles and low for `run_len`+2 cycles.
- R4: With `irq_spd_en` set, a cycle in which some line of `irq_lines` is 1 while its `irq_mask` bit is 0, or `smi_event` is 1, loads the interrupt window with `irq_count`. `speedup_active` is 1 after that clock edge whenever `irq_count` is nonzero.
- R5: An interrupt line whose `irq_mask` bit is 1 never starts a window.
- R6: With `vid_spd_en` set, a cycle with `video_event` at 1 or a decoded display access loads the video window with `vid_count`.
- R7: A bus access with `bus_valid`=1 and `bus_is_io`=1 counts as a display access exactly when `bus_addr[15:4]` is 03Bh, 03Ch or 03Dh.
- R8: A bus access with `bus_valid`=1 and `bus_is_io`=0 counts as a display access exactly when A0000h ≤ `bus_addr` ≤ B7FFFh.
- R9: Each cycle with `tick`=1 lowers a running window by one. A window loaded with N ends after N ticks.
- R10: A new trigger during a running window reloads that window to its full programmed count.
- R11: `speedup_active` stays 1 while either window is nonzero and falls only when both have reached zero.
- R12: In the cycle after `speedup_active` is 1, `susp_req` is 0.
- R13: While `mod_enable` is 0, no window starts and `susp_req` stays 0. A per-source enable at 0 blocks that source alone.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pm_enable | input | 1 | Global power-management enable |
| mod_enable | input | 1 | Suspend-modulation mode in use |
| irq_spd_en | input | 1 | Interrupt/SMI speedup enable |
| vid_spd_en | input | 1 | Video speedup enable |
| irq_count | input | 8 | Interrupt window length in ticks |
| vid_count | input | 8 | Video window length in ticks |
| run_len | input | 8 | Run-phase length in cycles |
| susp_len | input | 8 | Suspend-phase length in acknowledged cycles |
| irq_lines | input | NUM_IRQ | Interrupt request lines, active high |
| irq_mask | input | NUM_IRQ | Per-line mask, 1 = masked |
| smi_event | input | 1 | SMI indication |
| video_event | input | 1 | Video-activity pulse |
| bus_valid | input | 1 | Bus access present this cycle |
| bus_is_io | input | 1 | 1 = I/O access, 0 = memory access |
| bus_addr | input | ADDR_W | Bus access address |
| tick | input | 1 | Timebase tick for the window counters |
| susp_ack | input | 1 | Suspend acknowledge |
| susp_req | output | 1 | Suspend request |
| speedup_active | output | 1 | A speedup window is running |

## Verification
On every cycle, the embedded assertions check the following. A disabled block or a running window forces the suspend request low on the next cycle. A trigger reloads its window to the programmed value, and a tick lowers it by exactly one. A fully masked interrupt set with no SMI yields no event. A run phase never begins while the acknowledge is still held. Only the directed scenarios can show the rest: the exact run and suspend lengths of the duty pattern, the address boundaries of the display decode (3AFh/3B0h, 3DFh/3E0h, 9FFFFh/A0000h, B7FFFh/B8000h), reload on retrigger, and the window ending only when the longer of two overlapping windows has run out.

// File: rtl/throttle_pkg.sv
package throttle_pkg;

    localparam int CNT_W = 8;

    localparam logic [31:0] VGA_MEM_LO = 32'h000A_0000;
    localparam logic [31:0] VGA_MEM_HI = 32'h000B_7FFF;

    typedef enum logic [1:0] {
        MOD_IDLE = 2'd0,
        MOD_RUN  = 2'd1,
        MOD_SUSP = 2'd2
    } mod_state_e;

    typedef struct packed {
        logic irq;
        logic vid;
    } speedup_hit_t;

    function automatic logic vga_io_match(input logic [15:0] a);
        return (a[15:4] == 12'h03B) || (a[15:4] == 12'h03C) || (a[15:4] == 12'h03D);
    endfunction

    function automatic logic last_phase(input logic [CNT_W-1:0] phase,
                                        input logic [CNT_W-1:0] len);
        return ({1'b0, phase} + 9'd1) >= {1'b0, len};
    endfunction

endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge #(
    parameter int NUM_IRQ = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               smi_event,
    output logic               any_event
);
    logic [NUM_IRQ-1:0] live;

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
        assign live[i] = irq_lines[i] & ~irq_mask[i];
    end

    assign any_event = (|live) | smi_event;

    assert_masked_silent_R5: assert property (@(posedge clk) disable iff (rst)
        ((&irq_mask) && !smi_event) |-> !any_event);

endmodule

// File: rtl/vga_access_decode.sv
module vga_access_decode
    import throttle_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              bus_valid,
    input  logic              bus_is_io,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic              vga_hit
);
    logic io_hit;
    logic mem_hit;

    assign io_hit  = bus_is_io && vga_io_match(bus_addr[15:0]);
    assign mem_hit = !bus_is_io
                  && (bus_addr >= ADDR_W'(VGA_MEM_LO))
                  && (bus_addr <= ADDR_W'(VGA_MEM_HI));
    assign vga_hit = bus_valid && (io_hit || mem_hit);

endmodule

// File: rtl/speedup_window.sv
module speedup_window
    import throttle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic             hit,
    input  logic             tick,
    input  logic [CNT_W-1:0] load_val,
    output logic             active
);
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            cnt <= '0;
        end else if (hit) begin
            cnt <= load_val;
        end else if (tick && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign active = (cnt != '0);

    assert_reload_full_R10: assert property (@(posedge clk) disable iff (rst)
        (enable && hit) |=> (cnt == $past(load_val)));

    assert_tick_step_R9: assert property (@(posedge clk) disable iff (rst)
        (enable && !hit && tick && (cnt != '0)) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

endmodule

// File: rtl/duty_modulator.sv
module duty_modulator
    import throttle_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run_en,
    input  logic [CNT_W-1:0] run_len,
    input  logic [CNT_W-1:0] susp_len,
    input  logic             susp_ack,
    output logic             susp_req
);
    mod_state_e       state;
    logic [CNT_W-1:0] phase;

    always_ff @(posedge clk) begin
        if (rst || !run_en) begin
            state <= MOD_IDLE;
            phase <= '0;
        end else begin
            unique case (state)
                MOD_IDLE: begin
                    phase <= '0;
                    if (!susp_ack) state <= MOD_RUN;
                end
                MOD_RUN: begin
                    if (last_phase(phase, run_len)) begin
                        state <= MOD_SUSP;
                        phase <= '0;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                MOD_SUSP: begin
                    if (susp_ack) begin
                        if (last_phase(phase, susp_len)) begin
                            state <= MOD_IDLE;
                            phase <= '0;
                        end else begin
                            phase <= phase + 1'b1;
                        end
                    end
                end
                default: begin
                    state <= MOD_IDLE;
                    phase <= '0;
                end
            endcase
        end
    end

    assign susp_req = (state == MOD_SUSP);

    assert_override_drop_R12: assert property (@(posedge clk) disable iff (rst)
        !run_en |=> !susp_req);

    assert_wait_release_R3: assert property (@(posedge clk) disable iff (rst)
        (state == MOD_IDLE && susp_ack) |=> (state != MOD_RUN));

endmodule

// File: rtl/throttle_speedup_ctrl.sv
module throttle_speedup_ctrl
    import throttle_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int ADDR_W  = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               pm_enable,
    input  logic               mod_enable,
    input  logic               irq_spd_en,
    input  logic               vid_spd_en,
    input  logic [7:0]         irq_count,
    input  logic [7:0]         vid_count,
    input  logic [7:0]         run_len,
    input  logic [7:0]         susp_len,
    input  logic [NUM_IRQ-1:0] irq_lines,
    input  logic [NUM_IRQ-1:0] irq_mask,
    input  logic               smi_event,
    input  logic               video_event,
    input  logic               bus_valid,
    input  logic               bus_is_io,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic               tick,
    input  logic               susp_ack,
    output logic               susp_req,
    output logic               speedup_active
);
    logic         gate;
    logic         irq_any;
    logic         vga_hit;
    speedup_hit_t hits;
    logic         irq_win;
    logic         vid_win;

    assign gate = pm_enable && mod_enable;

    irq_event_merge #(.NUM_IRQ(NUM_IRQ)) u_irq_merge (
        .clk       (clk),
        .rst       (rst),
        .irq_lines (irq_lines),
        .irq_mask  (irq_mask),
        .smi_event (smi_event),
        .any_event (irq_any)
    );

    vga_access_decode #(.ADDR_W(ADDR_W)) u_vga_dec (
        .bus_valid (bus_valid),
        .bus_is_io (bus_is_io),
        .bus_addr  (bus_addr),
        .vga_hit   (vga_hit)
    );

    assign hits.irq = gate && irq_spd_en && irq_any;
    assign hits.vid = gate && vid_spd_en && (video_event || vga_hit);

    speedup_window u_irq_win (
        .clk      (clk),
        .rst      (rst),
        .enable   (gate),
        .hit      (hits.irq),
        .tick     (tick),
        .load_val (irq_count),
        .active   (irq_win)
    );

    speedup_window u_vid_win (
        .clk      (clk),
        .rst      (rst),
        .enable   (gate),
        .hit      (hits.vid),
        .tick     (tick),
        .load_val (vid_count),
        .active   (vid_win)
    );

    assign speedup_active = irq_win || vid_win;

    duty_modulator u_mod (
        .clk      (clk),
        .rst      (rst),
        .run_en   (gate && !speedup_active),
        .run_len  (run_len),
        .susp_len (susp_len),
        .susp_ack (susp_ack),
        .susp_req (susp_req)
    );

    assert_pm_off_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !pm_enable |=> (!speedup_active && !susp_req));

    assert_mode_off_quiet_R13: assert property (@(posedge clk) disable iff (rst)
        !mod_enable |=> (!speedup_active && !susp_req));

    assert_active_blocks_req_R12: assert property (@(posedge clk) disable iff (rst)
        speedup_active |=> !susp_req);

endmodule

// File: tb/throttle_speedup_ctrl_bench.sv
module throttle_speedup_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NUM_IRQ    = 16;
    localparam int ADDR_W     = 32;

    logic               clk = 1'b0;
    logic               rst;
    logic               pm_enable, mod_enable, irq_spd_en, vid_spd_en;
    logic [7:0]         irq_count, vid_count, run_len, susp_len;
    logic [NUM_IRQ-1:0] irq_lines, irq_mask;
    logic               smi_event, video_event, bus_valid, bus_is_io, tick;
    logic [ADDR_W-1:0]  bus_addr;
    logic               susp_ack;
    logic               hold_ack;
    logic               susp_req, speedup_active;

    int tests_run  = 0;
    int tests_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    // acknowledger: follows the request one cycle late, or is held high
    always_ff @(posedge clk) begin
        if (rst) susp_ack <= 1'b0;
        else     susp_ack <= hold_ack ? 1'b1 : susp_req;
    end

    throttle_speedup_ctrl #(.NUM_IRQ(NUM_IRQ), .ADDR_W(ADDR_W)) u_throttle_speedup_ctrl (
        .clk(clk), .rst(rst), .pm_enable(pm_enable), .mod_enable(mod_enable),
        .irq_spd_en(irq_spd_en), .vid_spd_en(vid_spd_en),
        .irq_count(irq_count), .vid_count(vid_count),
        .run_len(run_len), .susp_len(susp_len),
        .irq_lines(irq_lines), .irq_mask(irq_mask), .smi_event(smi_event),
        .video_event(video_event), .bus_valid(bus_valid), .bus_is_io(bus_is_io),
        .bus_addr(bus_addr), .tick(tick), .susp_ack(susp_ack),
        .susp_req(susp_req), .speedup_active(speedup_active)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests_run++;
        if (!ok) begin
            tests_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        pm_enable = 0; mod_enable = 0; irq_spd_en = 0; vid_spd_en = 0;
        irq_count = 8'd4; vid_count = 8'd4; run_len = 8'd3; susp_len = 8'd2;
        irq_lines = '0; irq_mask = '0; smi_event = 0; video_event = 0;
        bus_valid = 0; bus_is_io = 0; bus_addr = '0; tick = 0; hold_ack = 0;
        cyc(3);
        rst = 1'b0;
        cyc(1);
    endtask

    // all enabled, counters cleared
    task automatic arm();
        pm_enable = 0; cyc(1);
        pm_enable = 1; mod_enable = 1; irq_spd_en = 1; vid_spd_en = 1;
        cyc(1);
    endtask

    task automatic do_tick(input int n);
        repeat (n) begin tick = 1; cyc(1); tick = 0; end
    endtask

    task automatic pulse_irq(input logic [NUM_IRQ-1:0] v);
        irq_lines = v; cyc(1); irq_lines = '0;
    endtask

    task automatic bus_try(input bit io, input logic [ADDR_W-1:0] a, input bit exp, input string req);
        arm();
        vid_count = 8'd5;
        bus_valid = 1; bus_is_io = io; bus_addr = a;
        cyc(1);
        bus_valid = 0;
        check(speedup_active == exp, req, speedup_active, exp);
    endtask

    task automatic t_reset();
        do_reset();
        check(susp_req == 0, "R1 susp_req", susp_req, 0);
        check(speedup_active == 0, "R1 speedup_active", speedup_active, 0);
    endtask

    task automatic t_pm_off();
        do_reset();
        mod_enable = 1; irq_spd_en = 1; vid_spd_en = 1;
        pulse_irq(16'h0001); video_event = 1; cyc(1); video_event = 0;
        check(speedup_active == 0, "R2 no window", speedup_active, 0);
        cyc(10);
        check(susp_req == 0, "R2 no suspend", susp_req, 0);
    endtask

    task automatic t_modulation();
        int h1 = 0, l1 = 0, h2 = 0, guard = 0;
        do_reset();
        run_len = 8'd3; susp_len = 8'd2;
        pm_enable = 1; mod_enable = 1;
        while (!susp_req && guard < 50) begin cyc(1); guard++; end
        while (susp_req)  begin h1++; cyc(1); end
        while (!susp_req) begin l1++; cyc(1); end
        while (susp_req)  begin h2++; cyc(1); end
        check(h1 == 3, "R3 high length", h1, 3);
        check(l1 == 5, "R3 low length", l1, 5);
        check(h2 == 3, "R3 second high", h2, 3);
    endtask

    task automatic t_handshake();
        int guard = 0;
        bit stayed_low = 1;
        do_reset();
        run_len = 8'd2; susp_len = 8'd1;
        pm_enable = 1; mod_enable = 1;
        while (!susp_req && guard < 50) begin cyc(1); guard++; end
        hold_ack = 1;
        guard = 0;
        while (susp_req && guard < 50) begin cyc(1); guard++; end
        for (int i = 0; i < 20; i++) begin
            if (susp_req) stayed_low = 0;
            cyc(1);
        end
        check(stayed_low, "R3 waits for ack release", !stayed_low, 0);
        hold_ack = 0;
        guard = 0;
        while (!susp_req && guard < 20) begin cyc(1); guard++; end
        check(susp_req == 1, "R3 resumes after release", susp_req, 1);
    endtask

    task automatic t_irq();
        do_reset(); arm();
        irq_count = 8'd3;
        pulse_irq(16'h0100);
        check(speedup_active == 1, "R4 unmasked line", speedup_active, 1);
        arm();
        smi_event = 1; cyc(1); smi_event = 0;
        check(speedup_active == 1, "R4 smi", speedup_active, 1);
    endtask

    task automatic t_mask();
        do_reset(); arm();
        irq_mask = 16'h0100;
        pulse_irq(16'h0100);
        check(speedup_active == 0, "R5 masked line", speedup_active, 0);
        pulse_irq(16'h0101);
        check(speedup_active == 1, "R5 other line passes", speedup_active, 1);
        irq_mask = '0;
    endtask

    task automatic t_video();
        do_reset(); arm();
        video_event = 1; cyc(1); video_event = 0;
        check(speedup_active == 1, "R6 video pulse", speedup_active, 1);
    endtask

    task automatic t_io_decode();
        do_reset();
        bus_try(1, 32'h0000_03B0, 1, "R7 3B0");
        bus_try(1, 32'h0000_03DF, 1, "R7 3DF");
        bus_try(1, 32'h0000_03AF, 0, "R7 3AF");
        bus_try(1, 32'h0000_03E0, 0, "R7 3E0");
    endtask

    task automatic t_mem_decode();
        do_reset();
        bus_try(0, 32'h000A_0000, 1, "R8 A0000");
        bus_try(0, 32'h000B_7FFF, 1, "R8 B7FFF");
        bus_try(0, 32'h0009_FFFF, 0, "R8 9FFFF");
        bus_try(0, 32'h000B_8000, 0, "R8 B8000");
        bus_try(0, 32'h0000_03C0, 0, "R8 memory not io");
    endtask

    task automatic t_decrement();
        do_reset(); arm();
        irq_count = 8'd3;
        pulse_irq(16'h0001);
        do_tick(2);
        check(speedup_active == 1, "R9 after 2 of 3 ticks", speedup_active, 1);
        do_tick(1);
        check(speedup_active == 0, "R9 after 3 ticks", speedup_active, 0);
    endtask

    task automatic t_retrigger();
        do_reset(); arm();
        irq_count = 8'd4;
        pulse_irq(16'h0001);
        do_tick(2);
        pulse_irq(16'h0001);
        do_tick(3);
        check(speedup_active == 1, "R10 reloaded", speedup_active, 1);
        do_tick(1);
        check(speedup_active == 0, "R10 ends after full count", speedup_active, 0);
    endtask

    task automatic t_both();
        do_reset(); arm();
        irq_count = 8'd2; vid_count = 8'd5;
        irq_lines = 16'h0002; video_event = 1; cyc(1);
        irq_lines = '0; video_event = 0;
        do_tick(2);
        check(speedup_active == 1, "R11 video window holds", speedup_active, 1);
        do_tick(2);
        check(speedup_active == 1, "R11 still one left", speedup_active, 1);
        do_tick(1);
        check(speedup_active == 0, "R11 both zero", speedup_active, 0);
    endtask

    task automatic t_override();
        int guard = 0;
        do_reset(); arm();
        run_len = 8'd2; susp_len = 8'd8; irq_count = 8'd20;
        while (!susp_req && guard < 50) begin cyc(1); guard++; end
        check(susp_req == 1, "R12 suspended before event", susp_req, 1);
        pulse_irq(16'h0004);
        cyc(1);
        check(susp_req == 0, "R12 request dropped", susp_req, 0);
        cyc(10);
        check(susp_req == 0, "R12 held low in window", susp_req, 0);
    endtask

    task automatic t_mode_off();
        do_reset(); arm();
        mod_enable = 0;
        pulse_irq(16'h0001);
        check(speedup_active == 0, "R13 mode off", speedup_active, 0);
        cyc(10);
        check(susp_req == 0, "R13 no suspend", susp_req, 0);
        arm();
        irq_spd_en = 0;
        pulse_irq(16'h0001);
        check(speedup_active == 0, "R13 irq source off", speedup_active, 0);
        video_event = 1; cyc(1); video_event = 0;
        check(speedup_active == 1, "R13 video still on", speedup_active, 1);
    endtask

    initial begin
        rst = 1'b1;
        hold_ack = 0;
        t_reset();
        t_pm_off();
        t_modulation();
        t_handshake();
        t_irq();
        t_mask();
        t_video();
        t_io_decode();
        t_mem_decode();
        t_decrement();
        t_retrigger();
        t_both();
        t_override();
        t_mode_off();
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        tests_run++;
        tests_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests_run, tests_fail);
        $finish;
    end

endmodule